// File: doc/BRIEF.md
# GPIO Edge Interrupt Detector with Per-Pin Glitch Filter

This block watches a bank of asynchronous general-purpose input pins and turns selected transitions into a single interrupt request. Every pin first passes through a two-flop synchroniser. The synchronised level goes straight to a readable pin-level output. It also feeds the interrupt path, where an optional per-pin glitch filter sits in front of an edge detector. The filter accepts a new level only once that level has been sampled on two successive rising clock edges.

Each pin can be configured to trigger on rising edges only, or on any change. A detected event sets a sticky per-pin flag. A flag stays set until software writes a zero to its bit. The flags, masked by per-pin interrupt enables, are ORed into one request line. A global detection enable freezes all event detection while it is low.

Configuration goes through a simple write port. A 2-bit selector picks one of four per-pin registers, and a data word gives one bit per pin. Changing a pin's filter or trigger-mode bit resets that pin's detection state to its present level, so the change itself never raises an event.

Top module: `gpio_irq_unit`

## Requirements
- R1: After synchronous reset, `flag_q`, `pin_level` and `irq` are all zero. The filter enables, trigger modes and interrupt enables are all zero (filter off, rising-edge mode, masked).
- R2: In rising mode with the filter off, a high level first sampled at clock edge E sets that pin's flag at edge E+2. A falling transition sets nothing.
- R3: A pin whose mode bit is 1 (selector 1) sets its flag on both a rising and a falling transition.
- R4: Flags are sticky. A write with selector 3 clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged.
- R5: When a pin event and a clearing write for the same bit fall in the same cycle, the flag ends up set.
- R6: With the filter on (selector 0, bit 1), a level held over two successive sampling edges is accepted, and first sampled at edge E it sets the flag at edge E+4. A level present at only one sampling edge never sets a flag.
- R7: With the filter off, a level present at a single sampling edge is registered as an event.
- R8: `pin_level` equals the pin value sampled two edges earlier, whatever the filter setting. A pulse the filter rejects still shows on `pin_level`.
- R9: `irq` is high exactly when some flag is set and its interrupt enable bit (selector 2) is 1. A new enable value acts from the edge that stores it.
- R10: While `gpio_en` is low, no flag is set. A level that changed while it was low and is stable at re-enable raises no flag.
- R11: A write that changes a pin's filter or mode bit reinitialises that pin's detector to its current level. An event pending for that pin in the write cycle does not set its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_en | input | 1 | Detection enable; no events while low |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 filter enable, 1 trigger mode, 2 interrupt enable, 3 flag clear-by-zero |
| wr_data | input | NUM_PINS | Write data, one bit per pin |
| pin_level | output | NUM_PINS | Synchronised, unfiltered pin levels |
| flag_q | output | NUM_PINS | Sticky per-pin event flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_PINS set to 5. That odd, non-power-of-two width exercises the per-pin generate loop and the partial clear masks, and lets directed cases give every pin a distinct role (rising, any-change, unfiltered pulse, filtered pulse, set-versus-clear) while the random phase still toggles all pins together. The random phase flips filter and mode bits while pins move, and pulls the detection enable low at times, so reinitialisation and gating meet live transitions.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        SEL_FILTER = 2'd0,
        SEL_MODE   = 2'd1,
        SEL_IEN    = 2'd2,
        SEL_FLAGS  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic filt_en;
        logic any_edge;
    } pin_cfg_t;

    typedef struct packed {
        logic cand;
        logic stable;
        logic last;
    } det_state_t;

    function automatic logic edge_event(input logic det, input logic last,
                                        input logic any_edge);
        if (any_edge)
            return det ^ last;
        return det & ~last;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst)
            stg[0] <= '0;
        else
            stg[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= '0;
                else
                    stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q_sync = stg[LAST];
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     gpio_en,
    input  logic     lvl,
    input  pin_cfg_t cfg,
    input  logic     reinit,
    output logic     hit
);
    det_state_t st;
    logic       det;
    logic       restart;

    assign det     = cfg.filt_en ? st.stable : lvl;
    assign restart = reinit | ~gpio_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (restart) begin
            st.cand   <= lvl;
            st.stable <= lvl;
            st.last   <= lvl;
        end else begin
            st.cand <= lvl;
            if (lvl == st.cand)
                st.stable <= lvl;
            st.last <= det;
        end
    end

    assign hit = ~restart & edge_event(det, st.last, cfg.any_edge);
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_sel_e            sel,
    input  logic [NUM_PINS-1:0] wr_data,
    output pin_cfg_t            cfg [NUM_PINS],
    output logic [NUM_PINS-1:0] ien,
    output logic [NUM_PINS-1:0] reinit,
    output logic [NUM_PINS-1:0] keep_mask
);
    logic [NUM_PINS-1:0] filt_q;
    logic [NUM_PINS-1:0] mode_q;
    logic [NUM_PINS-1:0] ien_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= '0;
            mode_q <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_FILTER: filt_q <= wr_data;
                SEL_MODE:   mode_q <= wr_data;
                SEL_IEN:    ien_q  <= wr_data;
                default:    ;
            endcase
        end
    end

    always_comb begin
        reinit    = '0;
        keep_mask = '1;
        if (wr_en) begin
            case (sel)
                SEL_FILTER: reinit    = wr_data ^ filt_q;
                SEL_MODE:   reinit    = wr_data ^ mode_q;
                SEL_FLAGS:  keep_mask = wr_data;
                default:    ;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
            assign cfg[i].filt_en  = filt_q[i];
            assign cfg[i].any_edge = mode_q[i];
        end
    endgenerate

    assign ien = ien_q;
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] hit,
    input  logic [NUM_PINS-1:0] keep_mask,
    input  logic [NUM_PINS-1:0] ien,
    output logic [NUM_PINS-1:0] flags,
    output logic                irq
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (flags & keep_mask) | hit;
    end

    assign irq = |(flags & ien);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gpio_en,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [NUM_PINS-1:0] wr_data,
    output logic [NUM_PINS-1:0] pin_level,
    output logic [NUM_PINS-1:0] flag_q,
    output logic                irq
);
    localparam int SYNC_STAGES = 2;

    reg_sel_e            sel;
    pin_cfg_t            cfg [NUM_PINS];
    logic [NUM_PINS-1:0] cfg_ien;
    logic [NUM_PINS-1:0] reinit;
    logic [NUM_PINS-1:0] keep_mask;
    logic [NUM_PINS-1:0] pin_hit;

    assign sel = reg_sel_e'(wr_sel);

    gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (pin_level)
    );

    gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .sel       (sel),
        .wr_data   (wr_data),
        .cfg       (cfg),
        .ien       (cfg_ien),
        .reinit    (reinit),
        .keep_mask (keep_mask)
    );

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            gpio_irq_pin u_pin (
                .clk     (clk),
                .rst     (rst),
                .gpio_en (gpio_en),
                .lvl     (pin_level[i]),
                .cfg     (cfg[i]),
                .reinit  (reinit[i]),
                .hit     (pin_hit[i])
            );
        end
    endgenerate

    gpio_irq_flags #(.NUM_PINS(NUM_PINS)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .hit       (pin_hit),
        .keep_mask (keep_mask),
        .ien       (cfg_ien),
        .flags     (flag_q),
        .irq       (irq)
    );
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                gpio_en,
    input logic [NUM_PINS-1:0] pin_in,
    input logic                wr_en,
    input logic [1:0]          wr_sel,
    input logic [NUM_PINS-1:0] wr_data,
    input logic [NUM_PINS-1:0] pin_level,
    input logic [NUM_PINS-1:0] flag_q,
    input logic                irq,
    input logic [NUM_PINS-1:0] pin_hit
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|pin_hit) |=> ((flag_q & $past(pin_hit)) == $past(pin_hit)));

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == 2'd3) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3 && pin_hit == '0) |=>
            (flag_q == ($past(flag_q) & $past(wr_data))));

    // R10
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        !gpio_en |=> ((flag_q & ~$past(flag_q)) == '0));

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_q != '0));

    // R8
    level_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (pin_level == $past(pin_in, 2)));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .gpio_en   (gpio_en),
    .pin_in    (pin_in),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .pin_level (pin_level),
    .flag_q    (flag_q),
    .irq       (irq),
    .pin_hit   (pin_hit)
);

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          gpio_en = 1'b1;
    logic [NP-1:0] pin_in = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [NP-1:0] wr_data = '0;
    logic [NP-1:0] pin_level;
    logic [NP-1:0] flag_q;
    logic          irq;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [NP-1:0] m_s1, m_s2, m_d1, m_f, m_prev, m_flag, m_fe, m_any, m_ien;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_unit #(.NUM_PINS(NP)) uut (
        .clk       (clk),
        .rst       (rst),
        .gpio_en   (gpio_en),
        .pin_in    (pin_in),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pin_level (pin_level),
        .flag_q    (flag_q),
        .irq       (irq)
    );

    function automatic logic [NP-1:0] exp_edges(input logic [NP-1:0] det,
        input logic [NP-1:0] last, input logic [NP-1:0] any);
        return (any & (det ^ last)) | (~any & det & ~last);
    endfunction

    task automatic model_step();
        logic [NP-1:0] det, re, hit, keep;
        if (rst) begin
            {m_s1, m_s2, m_d1, m_f, m_prev, m_flag, m_fe, m_any, m_ien} = '0;
            return;
        end
        det  = (m_fe & m_f) | (~m_fe & m_s2);
        re   = '0;
        keep = '1;
        if (wr_en && wr_sel == 2'd0) re = wr_data ^ m_fe;
        if (wr_en && wr_sel == 2'd1) re = wr_data ^ m_any;
        if (wr_en && wr_sel == 2'd3) keep = wr_data;
        if (!gpio_en) re = '1;
        hit    = exp_edges(det, m_prev, m_any) & ~re;
        m_flag = (m_flag & keep) | hit;
        m_f    = (re & m_s2) | (~re & ~(m_s2 ^ m_d1) & m_s2) | (~re & (m_s2 ^ m_d1) & m_f);
        m_prev = (re & m_s2) | (~re & det);
        m_d1   = m_s2;
        if (wr_en && wr_sel == 2'd0) m_fe  = wr_data;
        if (wr_en && wr_sel == 2'd1) m_any = wr_data;
        if (wr_en && wr_sel == 2'd2) m_ien = wr_data;
        m_s2 = m_s1;
        m_s1 = pin_in;
    endtask

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) begin
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [NP-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 flags", flag_q, 0);
        chk("R1 irq", irq, 0);
        chk("R1 level", pin_level, 0);

        // R2 rising edge latency, R8 level latency
        pin_in[0] = 1'b1;
        cyc();
        chk("R8 level not yet", pin_level[0], 0);
        cyc();
        chk("R8 level after two edges", pin_level[0], 1);
        chk("R2 flag not before E+2", flag_q[0], 0);
        cyc();
        chk("R2 flag at E+2", flag_q[0], 1);
        wr(2'd3, '1);
        chk("R4 write ones keeps flag", flag_q[0], 1);
        wr(2'd3, 5'b11110);
        chk("R4 write zero clears", flag_q[0], 0);
        pin_in[0] = 1'b0;
        cyc(4);
        chk("R2 falling edge ignored", flag_q, 0);

        // R3 any-change mode on pin 1
        wr(2'd1, 5'b00010);
        pin_in[1] = 1'b1;
        cyc(4);
        chk("R3 rise in any mode", flag_q, 5'b00010);
        wr(2'd3, '0);
        pin_in[1] = 1'b0;
        cyc(4);
        chk("R3 fall in any mode", flag_q, 5'b00010);
        wr(2'd3, '0);

        // R7 single-edge pulse, filter off
        pin_in[2] = 1'b1;
        cyc();
        pin_in[2] = 1'b0;
        cyc(4);
        chk("R7 short pulse registered", flag_q, 5'b00100);
        wr(2'd3, '0);

        // R6 filter on pin 3
        wr(2'd0, 5'b01000);
        pin_in[3] = 1'b1;
        cyc();
        pin_in[3] = 1'b0;
        cyc();
        chk("R8 pulse visible with filter", pin_level[3], 1);
        cyc(4);
        chk("R6 one-edge pulse rejected", flag_q, 0);
        pin_in[3] = 1'b1;
        cyc(2);
        pin_in[3] = 1'b0;
        cyc(2);
        chk("R6 not before E+4", flag_q[3], 0);
        cyc();
        chk("R6 two-edge pulse at E+4", flag_q[3], 1);

        // R9 interrupt masking
        chk("R9 masked", irq, 0);
        wr(2'd2, 5'b01000);
        chk("R9 enabled", irq, 1);
        wr(2'd2, 5'b00001);
        chk("R9 other pin enabled", irq, 0);
        wr(2'd2, '1);
        wr(2'd3, '0);
        chk("R9 no flags no irq", irq, 0);

        // R5 set beats clear
        pin_in[4] = 1'b1;
        cyc(2);
        wr(2'd3, '0);
        chk("R5 set wins", flag_q[4], 1);
        wr(2'd3, '0);
        chk("R5 later clear", flag_q, 0);
        pin_in[4] = 1'b0;
        cyc(3);

        // R10 detection gating
        gpio_en = 1'b0;
        pin_in[0] = 1'b1;
        cyc(4);
        chk("R10 no flag while disabled", flag_q, 0);
        chk("R10 level still tracks", pin_level[0], 1);
        gpio_en = 1'b1;
        cyc(4);
        chk("R10 no flag after re-enable", flag_q, 0);
        pin_in[0] = 1'b0;
        cyc(3);
        pin_in[0] = 1'b1;
        cyc(3);
        chk("R10 detection resumes", flag_q[0], 1);
        pin_in[0] = 1'b0;
        cyc(3);
        wr(2'd3, '0);

        // R11 reconfiguration drops a pending event
        pin_in[0] = 1'b1;
        cyc(2);
        wr(2'd0, 5'b01001);
        chk("R11 no flag in reinit cycle", flag_q[0], 0);
        cyc(5);
        chk("R11 no late flag", flag_q[0], 0);

        // random phase against reference model
        pin_in = '0;
        do_reset();
        wr(2'd0, NP'($urandom));
        wr(2'd1, NP'($urandom));
        wr(2'd2, NP'($urandom));
        for (int c = 0; c < 2000; c++) begin
            logic [NP-1:0] flip;
            flip = '0;
            for (int b = 0; b < NP; b++)
                flip[b] = ($urandom % 4) == 0;
            pin_in  = pin_in ^ flip;
            gpio_en = ($urandom % 16) != 0;
            wr_en   = ($urandom % 8) == 0;
            wr_sel  = 2'($urandom);
            wr_data = NP'($urandom);
            cyc();
            chk("R2 R3 R4 R5 R6 R7 R10 R11 random flags", flag_q, m_flag);
            chk("R9 random irq", irq, |(m_flag & m_ien));
            chk("R8 random level", pin_level, m_s2);
        end
        wr_en = 1'b0;
        cyc(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule